// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the 4-bit opcode field of a 16-bit instruction into the control lines of a single-cycle datapath. It is purely combinational: the opcode presented on the input settles onto the control outputs in the same cycle, and the datapath registers act on them at the next clock edge. It has no clock and no reset of its own.

The outputs are a register-file write enable, a 4-bit ALU control word, a data-memory store enable, one memory-path select, a branch line, a jump line and a halt indication. The memory-path select steers three datapath multiplexers at once: the register write address, the register write data (memory instead of ALU), and the ALU second operand (immediate instead of register). The bitwise NAND operation runs on the existing ALU by inverting both operands and selecting OR. Bitwise NOT needs no opcode of its own: it is NAND with both source fields naming the same register. Opcodes with no assigned instruction behave like HALT.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 0000 (load word) gives write enable 1, ALU control 0010, store 0, memory select 1, branch 0, jump 0, halt 0.
- R2: Opcode 0001 (store word) gives write enable 0, ALU control 0010, store 1, memory select 1, branch 0, jump 0, halt 0.
- R3: Opcode 0010 (add) gives ALU control 0010 and opcode 0011 (subtract) gives 0110, both with write enable 1 and every other output 0.
- R4: Opcode 0100 (and) gives ALU control 0000 and opcode 0101 (or) gives 0001, both with write enable 1 and every other output 0.
- R5: Opcode 1001 (NAND, also used for NOT) gives write enable 1 and ALU control 1101, every other output 0.
- R6: Opcode 0111 (branch if equal) gives branch 1, ALU control 0110, write enable 0, and every other output 0.
- R7: Opcode 1000 (jump) gives jump 1, ALU control 0000, and every other output 0.
- R8: Opcode 1111 (halt) drives all control outputs to 0 and raises halt.
- R9: Undefined opcodes 0110 and 1010 through 1110 behave exactly as halt.
- R10: The ALU control word is ordered, MSB to LSB, invert-A, negate-B, op1, op0, where op 00 is AND, 01 is OR, 10 is ADD; memory select is 1 only for opcodes 0000 and 0001.
- R11: Branch, jump and halt are never active together, and store never coincides with write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 4 | Opcode field of the current instruction |
| reg_wr_o | output | 1 | Register file write enable |
| alu_ctl_o | output | 4 | ALU control: invert-A, negate-B, op1, op0 |
| mem_st_o | output | 1 | Data memory store enable |
| mem_sel_o | output | 1 | Selects memory path for write address, write data and ALU operand B |
| branch_o | output | 1 | Next PC from branch target when the equality test holds |
| jump_o | output | 1 | Next PC from the absolute jump target |
| halt_o | output | 1 | Halt or undefined opcode |

## Verification
The hardest case to reach is an undefined opcode: no instruction uses them, yet each must fall silently into the halt behaviour with every control line quiet. The stimulus sweeps all sixteen opcode values directly, so every undefined code is visited at least once, and then draws a long stream of opcodes from a seeded random source so that each decode is also reached from many different previous opcodes, catching any dependence on the prior value.

// File: rtl/cd_pkg.sv
package cd_pkg;
  localparam int OPC_W = 4;
  localparam int ALU_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_LW   = 4'b0000,
    OPC_SW   = 4'b0001,
    OPC_ADD  = 4'b0010,
    OPC_SUB  = 4'b0011,
    OPC_AND  = 4'b0100,
    OPC_OR   = 4'b0101,
    OPC_BEQ  = 4'b0111,
    OPC_JMP  = 4'b1000,
    OPC_NAND = 4'b1001,
    OPC_HALT = 4'b1111
  } opcode_e;

  // one-hot class indices
  localparam int C_LW   = 0;
  localparam int C_SW   = 1;
  localparam int C_ADD  = 2;
  localparam int C_SUB  = 3;
  localparam int C_AND  = 4;
  localparam int C_OR   = 5;
  localparam int C_BEQ  = 6;
  localparam int C_JMP  = 7;
  localparam int C_NAND = 8;
  localparam int C_HALT = 9;
  localparam int NCLS   = 10;
  localparam int NDEF   = NCLS - 1;

  typedef enum logic [1:0] {
    ALU_AND = 2'b00,
    ALU_OR  = 2'b01,
    ALU_ADD = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    inv_a;
    logic    neg_b;
    alu_op_e op;
  } alu_ctl_t;

  function automatic logic [OPC_W-1:0] class_code(input int idx);
    case (idx)
      C_LW:    class_code = OPC_LW;
      C_SW:    class_code = OPC_SW;
      C_ADD:   class_code = OPC_ADD;
      C_SUB:   class_code = OPC_SUB;
      C_AND:   class_code = OPC_AND;
      C_OR:    class_code = OPC_OR;
      C_BEQ:   class_code = OPC_BEQ;
      C_JMP:   class_code = OPC_JMP;
      C_NAND:  class_code = OPC_NAND;
      default: class_code = OPC_HALT;
    endcase
  endfunction
endpackage

// File: rtl/cd_opc_class.sv
module cd_opc_class
  import cd_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output logic [NCLS-1:0]  cls_o
);
  logic [NDEF-1:0] hit;

  for (genvar g = 0; g < NDEF; g++) begin : g_match
    assign hit[g] = (opcode_i == class_code(g));
  end

  // explicit halt and every unassigned code land in the halt class
  assign cls_o = {~|hit, hit};

  always_comb begin
    AST_CLASS_ONEHOT: assert ($onehot(cls_o)); // R9
  end
endmodule

// File: rtl/cd_alu_enc.sv
module cd_alu_enc
  import cd_pkg::*;
(
  input  logic [NCLS-1:0] cls_i,
  output alu_ctl_t        alu_o
);
  logic use_add, use_or;

  always_comb begin
    use_add     = cls_i[C_LW] | cls_i[C_SW] | cls_i[C_ADD] | cls_i[C_SUB] | cls_i[C_BEQ];
    // NAND via De Morgan: ~a | ~b; negate-B carry-in is unused by OR
    use_or      = cls_i[C_OR] | cls_i[C_NAND];
    alu_o.inv_a = cls_i[C_NAND];
    alu_o.neg_b = cls_i[C_SUB] | cls_i[C_BEQ] | cls_i[C_NAND];
    alu_o.op    = use_add ? ALU_ADD : (use_or ? ALU_OR : ALU_AND);
  end

  always_comb begin
    AST_INV_A_NEEDS_OR: assert (!alu_o.inv_a || alu_o.op == ALU_OR); // R5
  end
endmodule

// File: rtl/cd_ctl_enc.sv
module cd_ctl_enc
  import cd_pkg::*;
(
  input  logic [NCLS-1:0] cls_i,
  output logic            reg_wr_o,
  output logic            mem_st_o,
  output logic            mem_sel_o,
  output logic            branch_o,
  output logic            jump_o,
  output logic            halt_o
);
  always_comb begin
    reg_wr_o  = cls_i[C_LW] | cls_i[C_ADD] | cls_i[C_SUB] |
                cls_i[C_AND] | cls_i[C_OR] | cls_i[C_NAND];
    mem_st_o  = cls_i[C_SW];
    mem_sel_o = cls_i[C_LW] | cls_i[C_SW];
    branch_o  = cls_i[C_BEQ];
    jump_o    = cls_i[C_JMP];
    halt_o    = cls_i[C_HALT];
  end
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import cd_pkg::*;
(
  input  logic [3:0] opcode_i,
  output logic       reg_wr_o,
  output logic [3:0] alu_ctl_o,
  output logic       mem_st_o,
  output logic       mem_sel_o,
  output logic       branch_o,
  output logic       jump_o,
  output logic       halt_o
);
  logic [NCLS-1:0] cls;
  alu_ctl_t        alu;

  cd_opc_class i_class (.opcode_i(opcode_i), .cls_o(cls));
  cd_alu_enc   i_alu   (.cls_i(cls), .alu_o(alu));
  cd_ctl_enc   i_ctl   (.cls_i(cls), .reg_wr_o(reg_wr_o), .mem_st_o(mem_st_o),
                        .mem_sel_o(mem_sel_o), .branch_o(branch_o),
                        .jump_o(jump_o), .halt_o(halt_o));

  assign alu_ctl_o = alu;

  always_comb begin
    AST_HALT_QUIET: assert (!halt_o || (alu_ctl_o == 4'b0 && !reg_wr_o && !mem_st_o
                            && !mem_sel_o && !branch_o && !jump_o)); // R8
    AST_FLOW_EXCL:  assert ($onehot0({branch_o, jump_o, halt_o})); // R11
    AST_STORE_NO_WR: assert (!(mem_st_o && reg_wr_o)); // R11
    AST_MEMSEL_MEMOP: assert (!mem_sel_o || opcode_i[3:1] == 3'b000); // R10
    AST_BRANCH_SUBTRACTS: assert (!branch_o || alu_ctl_o == 4'b0110); // R6
    AST_JUMP_NO_WRITE: assert (!jump_o || (!reg_wr_o && !mem_st_o)); // R7
  end
endmodule

// File: tb/test_ctrl_decoder.sv
module test_ctrl_decoder;
  logic       clk = 1'b0;
  logic [3:0] opcode;
  logic       reg_wr, mem_st, mem_sel, branch, jump, halt;
  logic [3:0] alu_ctl;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  ctrl_decoder i_ctrl_decoder (
    .opcode_i(opcode), .reg_wr_o(reg_wr), .alu_ctl_o(alu_ctl), .mem_st_o(mem_st),
    .mem_sel_o(mem_sel), .branch_o(branch), .jump_o(jump), .halt_o(halt)
  );

  // {reg_wr, alu_ctl[3:0], mem_st, mem_sel, branch, jump, halt}
  function automatic logic [9:0] expect_of(input logic [3:0] op);
    case (op)
      4'b0000: expect_of = {1'b1, 4'b0010, 5'b01000};
      4'b0001: expect_of = {1'b0, 4'b0010, 5'b11000};
      4'b0010: expect_of = {1'b1, 4'b0010, 5'b00000};
      4'b0011: expect_of = {1'b1, 4'b0110, 5'b00000};
      4'b0100: expect_of = {1'b1, 4'b0000, 5'b00000};
      4'b0101: expect_of = {1'b1, 4'b0001, 5'b00000};
      4'b0111: expect_of = {1'b0, 4'b0110, 5'b00100};
      4'b1000: expect_of = {1'b0, 4'b0000, 5'b00010};
      4'b1001: expect_of = {1'b1, 4'b1101, 5'b00000};
      default: expect_of = {1'b0, 4'b0000, 5'b00001};
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'b0000: req_of = "R1";
      4'b0001: req_of = "R2";
      4'b0010, 4'b0011: req_of = "R3";
      4'b0100, 4'b0101: req_of = "R4";
      4'b1001: req_of = "R5";
      4'b0111: req_of = "R6";
      4'b1000: req_of = "R7";
      4'b1111: req_of = "R8";
      default: req_of = "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op);
    logic [9:0] act, exp;
    @(posedge clk);
    opcode = op;
    @(negedge clk);
    act = {reg_wr, alu_ctl, mem_st, mem_sel, branch, jump, halt};
    exp = expect_of(op);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s opcode=%b actual=%b expected=%b", req_of(op), op, act, exp);
    end
    // R10: memory select only for load/store; R11: exclusive flow lines
    n_checks++;
    if ((mem_sel && op[3:1] != 3'b000) || ($countones({branch, jump, halt}) > 1)
        || (mem_st && reg_wr)) begin
      n_fail++;
      $display("FAIL R10/R11 opcode=%b actual=%b expected=exclusive", op, act);
    end
  endtask

  initial begin
    void'($urandom(32'd20240));
    opcode = 4'b1111;
    // reset-like start: halt code at time zero
    @(negedge clk);
    n_checks++;
    if (halt !== 1'b1 || reg_wr !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 initial halt actual=%b expected=1", halt);
    end
    // directed sweep: every code, including R9 undefined ones
    for (int i = 0; i < 16; i++) apply(4'(i));
    // corner: store straight after load, branch after jump
    apply(4'b0000); apply(4'b0001); apply(4'b1000); apply(4'b0111);
    apply(4'b1001); apply(4'b0110); apply(4'b1110); apply(4'b1010);
    // random stream
    for (int k = 0; k < 400; k++) apply(4'($urandom_range(0, 15)));
    done = 1'b1;
  end

  initial begin
    for (int w = 0; w < 100000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule